// File: doc/BRIEF.md
# MDIO Management Master

This block runs one Clause 22 management transaction at a time toward an external PHY or switch. The host writes a single 32-bit command word. A go flag in that word starts the transaction. The block then shifts the complete management frame out on MDC/MDIO and drops the flag when the frame has ended, so the same bit reads back as a busy indication.

The command word packs four things: a 2-bit opcode, a 10-bit target address that the block splits into the PHY and register fields of the frame, the 16-bit payload for writes, and the go/busy flag. Read results go to a separate data register. That register changes only when a read finishes.

MDC is derived from the system clock through a half-period divider set by a parameter. At idle, MDC sits low and the MDIO driver is released.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, ctrl_rdata and data_rdata are 0, mdc is 0 and mdio_oe is 0.
- R2: A write of cmd_wdata with bit 15 set and a valid opcode while idle is accepted on that clock edge. Bit 15 of ctrl_rdata then reads 1 from that edge until exactly 128*MDC_HALF clock edges later, when it clears. The other bits keep the accepted word.
- R3: A command written while bit 15 of ctrl_rdata is 1 is ignored. The stored word and the frame in progress are unchanged.
- R4: Command bits 11:10 hold the opcode: 01 is a write and 10 is a read. A command with opcode 00 or 11, or with bit 15 clear, starts no frame (MDC stays low) and leaves ctrl_rdata unchanged.
- R5: Command bits 9:5 form the 5-bit PHY address field and bits 4:0 form the 5-bit register field of the frame.
- R6: A frame is 64 bits sent MSB first: 32 ones, start 01, opcode, PHY address, register, a 2-bit turnaround and 16 data bits.
- R7: In a write, the master drives MDIO for all 64 bits, sends turnaround 10, and sends command bits 31:16 as the data field.
- R8: In a read, the master drives bits 0..45 and releases MDIO (mdio_oe = 0) from the first turnaround bit to the end of the frame. It samples mdio_i at the 16 data-bit MDC rising edges. When the frame ends, data_rdata becomes {16'h0, received bits}.
- R9: MDC has a period of 2*MDC_HALF clock cycles and starts low. mdio_o and mdio_oe change only while MDC is low, so they are stable across every high phase.
- R10: While idle, mdio_oe and mdc are 0. data_rdata changes only when a read completes; write frames and ignored commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: data 31:16, go 15, opcode 11:10, PHY 9:5, register 4:0 |
| ctrl_rdata | output | 32 | Stored command word; bit 15 is busy |
| data_rdata | output | 32 | Read result in bits 15:0, upper bits 0 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Busy rises on the edge that accepts a command and falls exactly 128*MDC_HALF edges later. The bench counts falling clock edges from the acceptance edge and samples busy one cycle before that point and at it. Frame bits and output-enable values are captured at each MDC rising edge, a half MDC period after the master last changed them. The scoreboard compares each 64-bit frame against the expectation pushed by the driver as soon as the 64th rising edge arrives. The read result and the untouched data register are checked once busy has cleared, which is the edge where the result is written.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [1:0] {
    OPC_RSVD_LO = 2'b00,
    OPC_WRITE   = 2'b01,
    OPC_READ    = 2'b10,
    OPC_RSVD_HI = 2'b11
  } mdio_opc_e;

  localparam int unsigned CMD_W      = 32;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned GO_BIT     = 15;
  localparam int unsigned OPC_LSB    = 10;
  localparam int unsigned PHY_LSB    = 5;
  localparam int unsigned REG_LSB    = 0;
  localparam int unsigned WDATA_LSB  = 16;
  localparam int unsigned PRE_LEN    = 32;
  localparam int unsigned FRAME_LEN  = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int unsigned TA_POS     = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int unsigned RXD_POS    = TA_POS + 2;

  typedef struct packed {
    mdio_opc_e          opc;
    logic [ADDR_W-1:0]  phy;
    logic [ADDR_W-1:0]  regad;
    logic [DATA_W-1:0]  wdata;
  } mdio_cmd_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned MDC_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int unsigned CNT_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MDC_HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             term;

  always_comb begin
    term      = run && (cnt_q == CNT_LAST);
    cnt_d     = (!run || term) ? '0 : cnt_q + CNT_W'(1);
    mdc_d     = run ? (term ? ~mdc_q : mdc_q) : 1'b0;
    rise_tick = term && !mdc_q;
    fall_tick = term && mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  AST_MDC_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_q |-> run) else $error("mdc high without a frame"); // R9

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST) else $error("divider out of range"); // R9

endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_we,
  input  logic [CMD_W-1:0]     cmd_wdata,
  input  logic                 xfer_done,
  input  logic                 rd_done,
  input  logic [DATA_W-1:0]    rd_word,
  output logic                 start,
  output mdio_cmd_t            cmd,
  output logic [CMD_W-1:0]     ctrl_q,
  output logic [CMD_W-1:0]     data_q
);

  logic             busy;
  logic             opc_ok;
  mdio_opc_e        opc_in;
  logic [CMD_W-1:0] ctrl_d, data_d;
  logic             ctrl_en, data_en;

  always_comb begin
    busy      = ctrl_q[GO_BIT];
    opc_in    = mdio_opc_e'(cmd_wdata[OPC_LSB +: 2]);
    opc_ok    = (opc_in == OPC_WRITE) || (opc_in == OPC_READ);
    start     = cmd_we && !busy && cmd_wdata[GO_BIT] && opc_ok;
    cmd.opc   = opc_in;
    cmd.phy   = cmd_wdata[PHY_LSB +: ADDR_W];
    cmd.regad = cmd_wdata[REG_LSB +: ADDR_W];
    cmd.wdata = cmd_wdata[WDATA_LSB +: DATA_W];
  end

  always_comb begin
    ctrl_en = start || xfer_done;
    ctrl_d  = ctrl_q;
    if (start) begin
      ctrl_d = cmd_wdata;
    end else if (xfer_done) begin
      ctrl_d[GO_BIT] = 1'b0;
    end
    data_en = rd_done;
    data_d  = {{(CMD_W-DATA_W){1'b0}}, rd_word};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (data_en) data_q <= data_d;
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_done |=> ctrl_q[GO_BIT]) else $error("busy dropped early"); // R2

  AST_IGNORE_BUSY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_we && !xfer_done |=> $stable(ctrl_q)) else $error("write accepted while busy"); // R3

  AST_BAD_OPC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !opc_ok && !xfer_done |=> $stable(ctrl_q)) else $error("bad opcode accepted"); // R4

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(data_q)) else $error("data register changed"); // R10

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  mdio_cmd_t          cmd,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               run,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               xfer_done,
  output logic               rd_done,
  output logic [DATA_W-1:0]  rd_word
);

  localparam int unsigned IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] IDX_RXD  = IDX_W'(RXD_POS);

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_st_e;

  eng_st_e                st_q, st_d;
  logic [IDX_W-1:0]       idx_q, idx_d, idx_inc;
  logic [FRAME_LEN-1:0]   sh_q, sh_d;
  logic                   oe_q, oe_d;
  logic                   rd_q, rd_d;
  logic [DATA_W-1:0]      rx_q, rx_d;
  logic                   load_en, shift_en, samp_en, upd_en;
  logic                   is_wr;

  always_comb begin
    is_wr    = (cmd.opc == OPC_WRITE);
    idx_inc  = idx_q + IDX_W'(1);
    load_en  = (st_q == ENG_IDLE) && start;
    shift_en = (st_q == ENG_SHIFT) && fall_tick;
    samp_en  = (st_q == ENG_SHIFT) && rise_tick && rd_q && (idx_q >= IDX_RXD);
    upd_en   = load_en || shift_en;
    xfer_done = shift_en && (idx_q == IDX_LAST);

    st_d  = st_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    oe_d  = oe_q;
    rd_d  = rd_q;
    rx_d  = {rx_q[DATA_W-2:0], mdio_i};

    if (load_en) begin
      st_d  = ENG_SHIFT;
      idx_d = '0;
      sh_d  = {{PRE_LEN{1'b1}}, 2'b01, cmd.opc, cmd.phy, cmd.regad,
               (is_wr ? 2'b10 : 2'b11),
               (is_wr ? cmd.wdata : {DATA_W{1'b1}})};
      oe_d  = 1'b1;
      rd_d  = !is_wr;
    end else if (shift_en) begin
      if (idx_q == IDX_LAST) begin
        st_d = ENG_IDLE;
        oe_d = 1'b0;
      end else begin
        idx_d = idx_inc;
        sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
        oe_d  = !(rd_q && (idx_inc >= IDX_TA));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      idx_q <= '0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
      rd_q  <= 1'b0;
      rx_q  <= '0;
    end else begin
      if (upd_en) begin
        st_q  <= st_d;
        idx_q <= idx_d;
        sh_q  <= sh_d;
        oe_q  <= oe_d;
        rd_q  <= rd_d;
      end
      if (samp_en) rx_q <= rx_d;
    end
  end

  assign run     = (st_q == ENG_SHIFT);
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = oe_q;
  assign rd_done = xfer_done && rd_q;
  assign rd_word = rx_q;

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    run && rd_q && (idx_q >= IDX_TA) |-> !oe_q) else $error("read turnaround driven"); // R8

  AST_RD_HEADER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    run && (idx_q < IDX_TA) |-> oe_q) else $error("header not driven"); // R6

  AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    run && !rd_q |-> oe_q) else $error("write frame released"); // R7

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned MDC_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] ctrl_rdata,
  output logic [31:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic              start, run, rise_tick, fall_tick;
  logic              xfer_done, rd_done;
  logic [DATA_W-1:0] rd_word;
  mdio_cmd_t         cmd;

  mdio_cmd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .xfer_done (xfer_done),
    .rd_done   (rd_done),
    .rd_word   (rd_word),
    .start     (start),
    .cmd       (cmd),
    .ctrl_q    (ctrl_rdata),
    .data_q    (data_rdata)
  );

  mdio_mdc_gen #(.MDC_HALF(MDC_HALF)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd       (cmd),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .run       (run),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .xfer_done (xfer_done),
    .rd_done   (rd_done),
    .rd_word   (rd_word)
  );

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[GO_BIT] |-> !mdio_oe && !mdc) else $error("idle bus not released"); // R10

  AST_MDIO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe)) else $error("mdio moved while mdc high"); // R9

endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb_top;

  localparam int HALF      = 4;
  localparam int FRAME_CYC = 128 * HALF;
  localparam logic [63:0] RD_MASK = {{46{1'b1}}, {18{1'b0}}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        mdio_i = 1'b1;
  logic [31:0] ctrl_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.MDC_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  int bit_cnt = 0;
  int rise_total = 0;
  int frames_seen = 0;
  realtime t_first;
  logic [63:0] got_bits, got_oe;
  logic [15:0] phy_rd_data = 16'h0;
  logic [63:0] exp_frame_q[$];
  logic [63:0] exp_mask_q[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: capture frames at MDC rising edges and compare with the scoreboard
  always @(posedge mdc) begin
    logic [63:0] ef, em;
    rise_total++;
    if (bit_cnt == 0) t_first = $realtime;
    got_bits = {got_bits[62:0], mdio_o};
    got_oe   = {got_oe[62:0], mdio_oe};
    if (bit_cnt == 63) begin
      bit_cnt = 0;
      frames_seen++;
      check("R9 mdc period", 64'(int'(($realtime - t_first) / 1.0)), 64'(63 * 2 * HALF * 4));
      if (exp_frame_q.size() == 0) begin
        check("R3 R4 unexpected frame", 64'd1, 64'd0);
      end else begin
        ef = exp_frame_q.pop_front();
        em = exp_mask_q.pop_front();
        check("R8 R7 oe pattern", got_oe, em);
        check("R5 R6 R7 frame bits", got_bits & em, ef & em);
      end
    end else begin
      bit_cnt++;
    end
  end

  // device model: drives read data after the falling edge that opens each data bit
  always @(negedge mdc) begin
    if (bit_cnt >= 48) mdio_i <= phy_rd_data[63 - bit_cnt];
    else               mdio_i <= 1'b1;
  end

  function automatic logic [31:0] mk_cmd(input logic [15:0] d, input logic go,
                                         input logic [1:0] op, input logic [4:0] phy,
                                         input logic [4:0] rg);
    return {d, go, 3'b000, op, phy, rg};
  endfunction

  // driver: push the expected frame, then pulse the command strobe
  task automatic send(input logic [31:0] w, input bit push);
    if (push) begin
      if (w[11:10] == 2'b01) begin
        exp_frame_q.push_back({32'hFFFF_FFFF, 2'b01, w[11:10], w[9:5], w[4:0], 2'b10, w[31:16]});
        exp_mask_q.push_back({64{1'b1}});
      end else begin
        exp_frame_q.push_back({32'hFFFF_FFFF, 2'b01, w[11:10], w[9:5], w[4:0], 18'h0});
        exp_mask_q.push_back(RD_MASK);
      end
    end
    @(negedge clk);
    cmd_we    = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_we    = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2 * FRAME_CYC; i++) begin
      if (!ctrl_rdata[15]) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual busy %0d expected 0", ctrl_rdata[15]);
    finish_run();
  end

  initial begin
    logic [31:0] w, wb;
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl reset", 64'(ctrl_rdata), 64'h0);
    check("R1 data reset", 64'(data_rdata), 64'h0);
    check("R1 mdc reset", 64'(mdc), 64'h0);
    check("R1 oe reset", 64'(mdio_oe), 64'h0);

    // write with exact busy window
    w = mk_cmd(16'hA5C3, 1'b1, 2'b01, 5'd3, 5'd17);
    send(w, 1'b1);
    check("R2 busy after accept", 64'(ctrl_rdata[15]), 64'h1);
    repeat (FRAME_CYC - 1) @(negedge clk);
    check("R2 busy one cycle before end", 64'(ctrl_rdata[15]), 64'h1);
    @(negedge clk);
    check("R2 busy cleared", 64'(ctrl_rdata[15]), 64'h0);
    check("R2 stored word", 64'(ctrl_rdata), 64'(w & ~32'h8000));
    check("R10 write leaves data", 64'(data_rdata), 64'h0);
    check("R10 idle released", 64'({mdio_oe, mdc}), 64'h0);

    // read
    phy_rd_data = 16'h3C5A;
    send(mk_cmd(16'hFFFF, 1'b1, 2'b10, 5'd31, 5'd0), 1'b1);
    wait_idle();
    check("R8 read data", 64'(data_rdata), 64'h0000_3C5A);

    // command while busy
    w  = mk_cmd(16'h1234, 1'b1, 2'b01, 5'd1, 5'd2);
    wb = mk_cmd(16'hBEEF, 1'b1, 2'b01, 5'd9, 5'd9);
    send(w, 1'b1);
    repeat (10) @(negedge clk);
    send(wb, 1'b0);
    check("R3 busy write ignored", 64'(ctrl_rdata), 64'(w));
    wait_idle();
    check("R3 word kept", 64'(ctrl_rdata), 64'(w & ~32'h8000));
    check("R10 data unchanged", 64'(data_rdata), 64'h0000_3C5A);

    // ignored commands
    r0 = rise_total;
    send(mk_cmd(16'h1111, 1'b1, 2'b00, 5'd4, 5'd4), 1'b0);
    repeat (4 * HALF) @(negedge clk);
    send(mk_cmd(16'h2222, 1'b1, 2'b11, 5'd4, 5'd4), 1'b0);
    repeat (4 * HALF) @(negedge clk);
    send(mk_cmd(16'h3333, 1'b0, 2'b01, 5'd4, 5'd4), 1'b0);
    repeat (4 * HALF) @(negedge clk);
    check("R4 no mdc activity", 64'(rise_total), 64'(r0));
    check("R4 ctrl unchanged", 64'(ctrl_rdata), 64'(w & ~32'h8000));
    check("R4 data unchanged", 64'(data_rdata), 64'h0000_3C5A);

    // second read pattern, then a write that must not disturb it
    phy_rd_data = 16'h8001;
    send(mk_cmd(16'h0000, 1'b1, 2'b10, 5'h15, 5'h1F), 1'b1);
    wait_idle();
    check("R8 read data edge bits", 64'(data_rdata), 64'h0000_8001);
    send(mk_cmd(16'h0F0F, 1'b1, 2'b01, 5'h0A, 5'h15), 1'b1);
    wait_idle();
    check("R10 data after write", 64'(data_rdata), 64'h0000_8001);
    check("R10 idle released end", 64'({mdio_oe, mdc}), 64'h0);
    check("R6 all frames seen", 64'(frames_seen), 64'd5);
    check("R6 scoreboard empty", 64'(exp_frame_q.size()), 64'd0);
    finish_run();
  end

endmodule